// File: doc/BRIEF.md
# Flash Array Write-Protection Decoder

This block sits between the command decoder of a 2 MB serial NOR flash and its program/erase sequencer. It reads the protection configuration: a granularity bit, an end-select bit, a 3-bit size code and an invert bit. From these it works out the one contiguous protected address range. Every program or erase request is checked against that range. One cycle after the request strobe, the block returns a response flag and a grant bit.

The protected extent is a power-of-two fraction of the array. It is counted in 64 kB blocks or in 4 kB sectors and anchored at the top or the bottom of the address space. Two size codes lock the whole array. The invert bit replaces the region with its exact complement. An erase is refused when any byte of the unit it would clear lies inside the protected range. A page program is refused when its start address lies inside it. The current range is also driven out as inclusive lower and upper bounds, with a separate flag for an empty range. Each bound output is registered one cycle after the configuration it reflects.

Top module: `wp_guard`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_grant` are 0, `prot_none` is 1 and both bounds read 0.
- R2: `rsp_valid` equals `req_valid` of the previous cycle. `rsp_grant` is never 1 while `rsp_valid` is 0. Bounds and `prot_none` reflect the configuration of the previous cycle.
- R3: Size code 000 with `cfg_inv`=0 protects nothing. Every request is then granted.
- R4: With `cfg_gran`=0 (64 kB granularity), size codes 1 to 5 protect 64 kB × 2^(code−1), which is 1/32 up to 1/2 of the array. With `cfg_low`=0 the region ends at 1FFFFFh. With `cfg_low`=1 it starts at 000000h.
- R5: With `cfg_gran`=1 (4 kB granularity), codes 1, 2 and 3 protect 4, 8 and 16 kB. Codes 4 and 5 both protect 32 kB. The region sits at the end chosen by `cfg_low`.
- R6: Size codes 6 and 7 protect 000000h to 1FFFFFh whatever `cfg_gran` and `cfg_low` are.
- R7: With `cfg_inv`=1 the protected set is the exact complement of the set for `cfg_inv`=0. For example, granularity 0, top, code 1 gives 000000h to 1EFFFFh.
- R8: Bounds are inclusive. When the protected set is empty, `prot_none` is 1 and both bounds read 0.
- R9: Op code 00 (page program) is refused exactly when `req_addr` lies in the protected range.
- R10: Op code 01 (4 kB sector erase) is refused exactly when the 4 kB-aligned sector holding `req_addr` overlaps the range.
- R11: Op code 10 (64 kB block erase) is refused exactly when the 64 kB-aligned block holding `req_addr` overlaps the range. Op code 11 (chip erase) is refused exactly when anything is protected.
- R12: A request is judged against the configuration present in the same cycle as its strobe, even when that configuration changes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gran | input | 1 | 1: 4 kB sector granularity, 0: 64 kB block granularity |
| cfg_low | input | 1 | 1: region anchored at address 0, 0: at the top |
| cfg_size | input | 3 | Power-of-two extent code |
| cfg_inv | input | 1 | Complement the protected set |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 21 | Byte address of the request |
| req_op | input | 2 | 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_grant | output | 1 | 1 when the operation is permitted |
| prot_lo | output | 21 | Inclusive lower bound of the protected range |
| prot_hi | output | 21 | Inclusive upper bound of the protected range |
| prot_none | output | 1 | Protected set is empty |

## Verification
Range decoding and request judging happen in the same cycle. A configuration change can therefore land on the very cycle that carries a request strobe. The bench provokes this for every one of the 64 configurations: the first request of each configuration is driven together with the new settings, aimed at the new lower bound. The response is judged only against a range computed arithmetically from the new settings. It is also judged on the bounds that emerge in the same response cycle. Any leftover from the previous configuration would therefore show as a wrong grant or a wrong bound.

// File: rtl/wp_pkg.sv
package wp_pkg;
    parameter int ADDR_W  = 21;
    parameter int SECT_LG = 12;
    parameter int BLK_LG  = 16;
    parameter int CODE_W  = 3;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_BLK  = 2'd2,
        OP_CHIP = 2'd3
    } op_e;

    typedef struct packed {
        logic  none;
        addr_t lo;
        addr_t hi;
    } span_t;
endpackage

// File: rtl/wp_range_calc.sv
module wp_range_calc
    import wp_pkg::*;
(
    input  logic              gran,
    input  logic              low_end,
    input  logic [CODE_W-1:0] size_code,
    input  logic              inv,
    output span_t             prot
);
    localparam addr_t TOP = '1;
    localparam logic [4:0] BLK_BASE  = 5'(BLK_LG - 1);
    localparam logic [4:0] SECT_BASE = 5'(SECT_LG - 1);
    localparam logic [4:0] SECT_CAP  = 5'(SECT_LG + 3);

    logic       base_none;
    logic       base_all;
    logic [4:0] lg;
    addr_t      mask;

    always_comb begin
        base_none = (size_code == '0);
        base_all  = (size_code[CODE_W-1:CODE_W-2] == 2'b11);
        if (!gran)
            lg = BLK_BASE + 5'(size_code);
        else if (!size_code[CODE_W-1])
            lg = SECT_BASE + 5'(size_code);
        else
            lg = SECT_CAP;
        mask = (addr_t'(1) << lg) - addr_t'(1);

        prot = '{1'b1, addr_t'(0), addr_t'(0)};
        if (!inv) begin
            if (base_all)
                prot = '{1'b0, addr_t'(0), TOP};
            else if (!base_none)
                prot = low_end ? '{1'b0, addr_t'(0), mask}
                               : '{1'b0, ~mask, TOP};
        end else begin
            if (base_none)
                prot = '{1'b0, addr_t'(0), TOP};
            else if (!base_all)
                prot = low_end ? '{1'b0, mask + addr_t'(1), TOP}
                               : '{1'b0, addr_t'(0), ~mask - addr_t'(1)};
        end
    end
endmodule

// File: rtl/wp_unit_span.sv
module wp_unit_span
    import wp_pkg::*;
(
    input  addr_t      addr,
    input  logic [1:0] op,
    output addr_t      u_lo,
    output addr_t      u_hi
);
    localparam addr_t SECT_M = addr_t'((1 << SECT_LG) - 1);
    localparam addr_t BLK_M  = addr_t'((1 << BLK_LG) - 1);

    always_comb begin
        unique case (op_e'(op))
            OP_PROG: begin u_lo = addr;           u_hi = addr;          end
            OP_SECT: begin u_lo = addr & ~SECT_M; u_hi = addr | SECT_M; end
            OP_BLK:  begin u_lo = addr & ~BLK_M;  u_hi = addr | BLK_M;  end
            default: begin u_lo = '0;             u_hi = '1;            end
        endcase
    end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_gran,
    input  logic              cfg_low,
    input  logic [CODE_W-1:0] cfg_size,
    input  logic              cfg_inv,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_op,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic [ADDR_W-1:0] prot_lo,
    output logic [ADDR_W-1:0] prot_hi,
    output logic              prot_none
);
    typedef struct packed {
        logic  vld;
        logic  grant;
        span_t prot;
    } state_t;

    localparam state_t RST_ST = '{1'b0, 1'b0, '{1'b1, addr_t'(0), addr_t'(0)}};

    state_t st_d, st_q;
    span_t  prot_now;
    addr_t  u_lo, u_hi;
    logic   hit;

    wp_range_calc u_range (
        .gran      (cfg_gran),
        .low_end   (cfg_low),
        .size_code (cfg_size),
        .inv       (cfg_inv),
        .prot      (prot_now)
    );

    wp_unit_span u_span (
        .addr (req_addr),
        .op   (req_op),
        .u_lo (u_lo),
        .u_hi (u_hi)
    );

    always_comb begin
        hit         = !prot_now.none && (u_lo <= prot_now.hi) && (u_hi >= prot_now.lo);
        st_d        = st_q;
        st_d.vld    = req_valid;
        st_d.grant  = req_valid && !hit;
        st_d.prot   = prot_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_grant = st_q.grant;
    assign prot_lo   = st_q.prot.lo;
    assign prot_hi   = st_q.prot.hi;
    assign prot_none = st_q.prot.none;
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk
    import wp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_gran,
    input logic              cfg_low,
    input logic [CODE_W-1:0] cfg_size,
    input logic              cfg_inv,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic              rsp_valid,
    input logic              rsp_grant,
    input logic [ADDR_W-1:0] prot_lo,
    input logic [ADDR_W-1:0] prot_hi,
    input logic              prot_none
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_grant_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> rsp_valid);
    p_bound_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_none |-> (prot_lo <= prot_hi));
    p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        prot_none |-> (prot_lo == '0 && prot_hi == '0));
    p_default_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_size == '0 && !cfg_inv) |=> prot_none);
    p_full_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_size[2:1] == 2'b11 && !cfg_inv) |=> (!prot_none && prot_lo == '0 && prot_hi == TOP));
    p_bottom_anchor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_size != '0 && cfg_low && !cfg_inv) |=> (!prot_none && prot_lo == '0));
    p_chip_erase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> (rsp_grant == prot_none));
endmodule

bind wp_guard wp_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_gran  (cfg_gran),
    .cfg_low   (cfg_low),
    .cfg_size  (cfg_size),
    .cfg_inv   (cfg_inv),
    .req_valid (req_valid),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .prot_lo   (prot_lo),
    .prot_hi   (prot_hi),
    .prot_none (prot_none)
);

// File: tb/tb_wp_guard.sv
module tb_wp_guard;
    localparam int MAXA = 32'h1FFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_gran = 1'b0, cfg_low = 1'b0, cfg_inv = 1'b0;
    logic [2:0]  cfg_size = 3'd0;
    logic        req_valid = 1'b0;
    logic [20:0] req_addr = '0;
    logic [1:0]  req_op = 2'd0;
    logic        rsp_valid, rsp_grant, prot_none;
    logic [20:0] prot_lo, prot_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wp_guard dut (
        .clk(clk), .rst_n(rst_n), .cfg_gran(cfg_gran), .cfg_low(cfg_low),
        .cfg_size(cfg_size), .cfg_inv(cfg_inv), .req_valid(req_valid),
        .req_addr(req_addr), .req_op(req_op), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .prot_lo(prot_lo), .prot_hi(prot_hi),
        .prot_none(prot_none)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int e_lo, e_hi;
    bit e_none;

    task automatic model(input bit g, input bit lw, input int sz, input bit iv);
        int ext;
        bit bnone, ball;
        bnone = (sz == 0);
        ball  = (sz >= 6);
        if (g == 0)      ext = 65536 * (2 ** (sz - 1));
        else if (sz < 4) ext = 4096 * (2 ** (sz - 1));
        else             ext = 32768;
        e_none = 0; e_lo = 0; e_hi = 0;
        if (!iv) begin
            if (bnone)   e_none = 1;
            else if (ball) e_hi = MAXA;
            else if (lw) e_hi = ext - 1;
            else begin e_lo = MAXA + 1 - ext; e_hi = MAXA; end
        end else begin
            if (ball)       e_none = 1;
            else if (bnone) e_hi = MAXA;
            else if (lw) begin e_lo = ext; e_hi = MAXA; end
            else            e_hi = MAXA - ext;
        end
    endtask

    function automatic int exp_grant(input int a, input int op);
        int ulo, uhi;
        case (op)
            0: begin ulo = a; uhi = a; end
            1: begin ulo = (a / 4096) * 4096; uhi = ulo + 4095; end
            2: begin ulo = (a / 65536) * 65536; uhi = ulo + 65535; end
            default: begin ulo = 0; uhi = MAXA; end
        endcase
        if (e_none) return 1;
        return (ulo <= e_hi && uhi >= e_lo) ? 0 : 1;
    endfunction

    function automatic int clip(input int a);
        if (a < 0) return 0;
        if (a > MAXA) return MAXA;
        return a;
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0: return "R9 program";
            1: return "R10 sector";
            2: return "R11 block";
            default: return "R11 chip";
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cand[8];
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 prot_none", int'(prot_none), 1);
        chk("R1 bounds", int'(prot_lo) + int'(prot_hi), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle valid", int'(rsp_valid), 0);
        chk("R2 idle grant", int'(rsp_grant), 0);

        for (int c = 0; c < 64; c++) begin
            bit g, lw, iv;
            int sz;
            string rtag;
            g  = c[5]; lw = c[4]; iv = c[3]; sz = c % 8;
            model(g, lw, sz, iv);
            if (iv)           rtag = "R7";
            else if (sz == 0) rtag = "R3";
            else if (sz >= 6) rtag = "R6";
            else if (g)       rtag = "R5";
            else              rtag = "R4";
            // R12: configuration and request in the same cycle
            cfg_gran = g; cfg_low = lw; cfg_size = 3'(sz); cfg_inv = iv;
            req_valid = 1'b1; req_op = 2'd0; req_addr = 21'(e_lo);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R12 same-cycle grant", int'(rsp_grant), exp_grant(e_lo, 0));
            chk("R2 valid", int'(rsp_valid), 1);
            chk({rtag, " R8 none"}, int'(prot_none), int'(e_none));
            chk({rtag, " R8 lo"}, int'(prot_lo), e_lo);
            chk({rtag, " R8 hi"}, int'(prot_hi), e_hi);

            cand = '{0, MAXA, clip(e_lo - 1), e_lo, e_hi, clip(e_hi + 1),
                     clip(e_lo + 4096), clip(e_hi - 4096)};
            for (int k = 0; k < 8; k++) begin
                for (int op = 0; op < 4; op++) begin
                    req_valid = 1'b1; req_op = 2'(op); req_addr = 21'(cand[k]);
                    @(negedge clk);
                    chk({rtag, " ", op_tag(op)}, int'(rsp_grant), exp_grant(cand[k], op));
                end
            end
            req_valid = 1'b0;
            @(negedge clk);
            chk("R2 drop valid", int'(rsp_valid), 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule